// File: doc/BRIEF.md
# Repeated Sub-Machine Launcher

This block is a pair of cooperating state machines. A controller sits idle until a start pulse arrives. It then launches a worker machine a fixed number of times, one run after another. The worker steps through a short fixed sequence of states and holds a busy flag high for the whole sequence. The busy flag drops only when the worker is back in its idle state.

The controller sends each launch as a single-cycle pulse. A run counts as complete only after the controller has seen busy go high and then low again, so a stale low level from the previous run is never taken as completion. After each completion the controller starts a fresh run, until the configured number of runs is reached. At that point it pulses done for one cycle and returns to idle.

The run count and the sequence length are parameters. All pins are plain control and status signals with no flow control. A start pulse that arrives while the controller is active is dropped.

Top module: `burst_sequencer`

## Requirements
- R1: An active-high synchronous reset returns both machines to idle within one clock edge: busy low, done low, run_count zero. They stay idle until a start is seen.
- R2: A start sampled while the controller is idle begins a new activation, and run_count reads zero in the following cycle.
- R3: Each launch makes busy high for exactly STEPS consecutive cycles (3 by default). The first busy cycle is the second cycle after the start or completion edge that requested the launch.
- R4: Each activation launches the worker exactly RUNS times (2 by default), seen as RUNS rising transitions of busy.
- R5: Between two runs of one activation, busy is low for exactly 2 cycles: one cycle to detect the fall and one cycle for the launch pulse.
- R6: run_count rises by one in the cycle after each busy window ends, and it never exceeds RUNS.
- R7: done is high for exactly one cycle. That cycle is 1 + RUNS*(STEPS+2) cycles after the cycle in which start was high, and run_count equals RUNS during it.
- R8: A start that is high while an activation is in progress has no effect. This holds for a pulse at any point and for a level held across the run; busy, done and run_count follow the same trace as for a single start pulse.
- R9: After the last run, busy stays low until a new start arrives. A start that is high in the same cycle as done is accepted as a new activation.
- R10: The launch request to the worker is never high for two cycles in a row, and every launch is followed by a rising busy.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin an activation when the controller is idle |
| busy | output | 1 | High while the worker machine is away from idle |
| done | output | 1 | One-cycle pulse when the last run completes |
| run_count | output | $clog2(RUNS+1) (2 by default) | Runs completed in the current or last activation |

## Verification
Two events can land in the same cycle: the controller finishing an activation with its done pulse, and a new start request. The bench raises start in the exact cycle where done is expected. It then checks that run_count clears to zero on the next edge and that a full second activation follows with the same cycle-exact busy and done trace. A second collision is a start pulse placed in the cycle where the controller detects busy falling. It is judged by comparing the whole busy, done and run_count trace against the single-pulse expectation.

// File: rtl/bseq_pkg.sv
package bseq_pkg;
  typedef enum logic [1:0] {
    CT_IDLE,
    CT_LAUNCH,
    CT_WAIT_HI,
    CT_WAIT_LO
  } ctrl_state_t;

  typedef enum logic {
    WK_IDLE,
    WK_RUN
  } work_state_t;
endpackage

// File: rtl/bseq_worker.sv
module bseq_worker #(
  parameter int STEPS = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic launch,
  output logic busy
);
  import bseq_pkg::*;

  localparam int SW = $clog2(STEPS + 1);
  localparam logic [SW-1:0] LAST_STEP = SW'(STEPS - 1);

  work_state_t     state;
  logic [SW-1:0]   step;

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= WK_IDLE;
      step  <= '0;
    end else begin
      case (state)
        WK_IDLE: begin
          step <= '0;
          if (launch) state <= WK_RUN;
        end
        WK_RUN: begin
          if (step == LAST_STEP) begin
            state <= WK_IDLE;
            step  <= '0;
          end else begin
            step <= step + 1'b1;
          end
        end
        default: state <= WK_IDLE;
      endcase
    end
  end

  // idle state itself is what pulls the flag low
  assign busy = (state != WK_IDLE);
endmodule

// File: rtl/bseq_run_counter.sv
module bseq_run_counter #(
  parameter int RUNS = 2,
  parameter int CW   = $clog2(RUNS + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          inc,
  output logic [CW-1:0] count,
  output logic          last
);
  localparam logic [CW-1:0] FINAL_IDX = CW'(RUNS - 1);

  always_ff @(posedge clk) begin
    if (rst || clr) count <= '0;
    else if (inc)   count <= count + 1'b1;
  end

  assign last = (count == FINAL_IDX);
endmodule

// File: rtl/bseq_controller.sv
module bseq_controller (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic busy,
  input  logic last,
  output logic launch,
  output logic clr,
  output logic inc,
  output logic done
);
  import bseq_pkg::*;

  ctrl_state_t state;

  assign launch = (state == CT_LAUNCH);
  assign clr    = (state == CT_IDLE) && start;
  assign inc    = (state == CT_WAIT_LO) && !busy;

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= CT_IDLE;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        CT_IDLE:    if (start) state <= CT_LAUNCH;
        CT_LAUNCH:  state <= CT_WAIT_HI;
        CT_WAIT_HI: if (busy) state <= CT_WAIT_LO;
        CT_WAIT_LO: begin
          if (!busy) begin
            if (last) begin
              state <= CT_IDLE;
              done  <= 1'b1;
            end else begin
              state <= CT_LAUNCH;
            end
          end
        end
        default: state <= CT_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/burst_sequencer.sv
module burst_sequencer #(
  parameter int RUNS  = 2,
  parameter int STEPS = 3,
  parameter int CW    = $clog2(RUNS + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  output logic          busy,
  output logic          done,
  output logic [CW-1:0] run_count
);
  logic launch_pulse;
  logic cnt_clr;
  logic cnt_inc;
  logic cnt_last;

  bseq_controller u_ctrl (
    .clk    (clk),
    .rst    (rst),
    .start  (start),
    .busy   (busy),
    .last   (cnt_last),
    .launch (launch_pulse),
    .clr    (cnt_clr),
    .inc    (cnt_inc),
    .done   (done)
  );

  bseq_worker #(.STEPS(STEPS)) u_work (
    .clk    (clk),
    .rst    (rst),
    .launch (launch_pulse),
    .busy   (busy)
  );

  bseq_run_counter #(.RUNS(RUNS), .CW(CW)) u_cnt (
    .clk   (clk),
    .rst   (rst),
    .clr   (cnt_clr),
    .inc   (cnt_inc),
    .count (run_count),
    .last  (cnt_last)
  );
endmodule

// File: rtl/burst_sequencer_chk.sv
module burst_sequencer_chk #(
  parameter int RUNS  = 2,
  parameter int STEPS = 3,
  parameter int CW    = $clog2(RUNS + 1)
) (
  input logic          clk,
  input logic          rst,
  input logic          busy,
  input logic          done,
  input logic [CW-1:0] run_count,
  input logic          launch
);
  localparam int BW = $clog2(STEPS + 1) + 1;

  logic [BW-1:0] blen;

  always_ff @(posedge clk) begin
    if (rst)       blen <= '0;
    else if (busy) blen <= blen + 1'b1;
    else           blen <= '0;
  end

  AST_RESET_IDLE: assert property (@(posedge clk)
    $past(rst) |-> (!busy && !done && run_count == '0)); // R1

  AST_BUSY_MAX_LEN: assert property (@(posedge clk) disable iff (rst)
    busy |-> (blen < BW'(STEPS))); // R3

  AST_BUSY_FULL_LEN: assert property (@(posedge clk) disable iff (rst)
    ($fell(busy) && !$past(rst)) |-> (blen == BW'(STEPS))); // R3

  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (rst)
    run_count <= CW'(RUNS)); // R6

  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (rst)
    (run_count != $past(run_count)) |->
      (run_count == '0 || run_count == $past(run_count) + 1'b1)); // R6

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R7

  AST_DONE_AT_FINAL: assert property (@(posedge clk) disable iff (rst)
    done |-> (run_count == CW'(RUNS))); // R7

  AST_LAUNCH_SINGLE: assert property (@(posedge clk) disable iff (rst)
    launch |=> !launch); // R10

  AST_LAUNCH_RAISES_BUSY: assert property (@(posedge clk) disable iff (rst)
    launch |=> $rose(busy)); // R10
endmodule

bind burst_sequencer burst_sequencer_chk #(
  .RUNS(RUNS), .STEPS(STEPS), .CW(CW)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .busy      (busy),
  .done      (done),
  .run_count (run_count),
  .launch    (launch_pulse)
);

// File: tb/test_burst_sequencer.sv
`timescale 1ns/1ps
module test_burst_sequencer;
  localparam int RUNS  = 2;
  localparam int STEPS = 3;
  localparam int CW    = $clog2(RUNS + 1);
  localparam int PER   = STEPS + 2;
  localparam int TOTAL = 1 + RUNS * PER;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start = 1'b0;
  logic          busy;
  logic          done;
  logic [CW-1:0] run_count;

  int errors = 0;
  int checks = 0;

  always #2.5 clk = ~clk;

  burst_sequencer #(.RUNS(RUNS), .STEPS(STEPS)) i_burst_sequencer (
    .clk(clk), .rst(rst), .start(start),
    .busy(busy), .done(done), .run_count(run_count)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int exp_busy(int n);
    return (n >= 2 && (n - 2) < RUNS * PER && ((n - 2) % PER) < STEPS) ? 1 : 0;
  endfunction

  function automatic int exp_cnt(int n);
    int c = (n - 1) / PER;
    return (c > RUNS) ? RUNS : c;
  endfunction

  task automatic step_edge();
    @(posedge clk);
    @(negedge clk);
  endtask

  // called at a negedge with the controller idle
  task automatic run_trace(input string tag, input int hold_len,
                           input int extra_at, input bit chain);
    int rises = 0;
    int low_run = 0;
    int prev_b = 0;
    int last_n = chain ? TOTAL : TOTAL + 4;
    start = 1'b1;
    for (int n = 1; n <= last_n; n++) begin
      step_edge();
      chk(busy == exp_busy(n), {tag, " R3 busy"}, busy, exp_busy(n));
      chk(run_count == exp_cnt(n), {tag, " R6 run_count"}, run_count, exp_cnt(n));
      chk(done == (n == TOTAL), {tag, " R7 done"}, done, (n == TOTAL));
      if (n == 1) chk(run_count == 0, {tag, " R2 cleared"}, run_count, 0);
      if (n > TOTAL) chk(busy == 0, {tag, " R9 quiet after done"}, busy, 0);
      if (busy && !prev_b) begin
        if (rises > 0) chk(low_run == 2, {tag, " R5 gap"}, low_run, 2);
        rises++;
        low_run = 0;
      end else if (!busy) begin
        low_run++;
      end
      prev_b = busy;
      start = (n < hold_len) || (n == extra_at);
      if (chain && n == TOTAL) start = 1'b1;
    end
    chk(rises == RUNS, {tag, " R4 launches"}, rises, RUNS);
  endtask

  task automatic t_reset_state();
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk(busy == 0, "R1 reset busy", busy, 0);
    chk(done == 0, "R1 reset done", done, 0);
    chk(run_count == 0, "R1 reset run_count", run_count, 0);
    rst = 1'b0;
    repeat (3) step_edge();
    chk(busy == 0, "R1 idle without start", busy, 0);
  endtask

  task automatic t_single();
    run_trace("single", 1, 0, 1'b0);
  endtask

  task automatic t_held_level();
    run_trace("held R8", TOTAL - 1, 0, 1'b0);
  endtask

  task automatic t_mid_pulses();
    run_trace("pulse@detect R8", 1, PER, 1'b0);
    run_trace("pulse@launch R8", 1, 2, 1'b0);
    run_trace("pulse@last R8", 1, TOTAL - 1, 1'b0);
  endtask

  task automatic t_back_to_back();
    run_trace("b2b first R9", 1, 0, 1'b1);
    run_trace("b2b second R9", 1, 0, 1'b0);
  endtask

  task automatic t_reset_mid();
    start = 1'b1;
    step_edge();
    start = 1'b0;
    repeat (PER + 1) step_edge();
    rst = 1'b1;
    step_edge();
    chk(busy == 0, "R1 mid reset busy", busy, 0);
    chk(done == 0, "R1 mid reset done", done, 0);
    chk(run_count == 0, "R1 mid reset run_count", run_count, 0);
    rst = 1'b0;
    for (int k = 0; k < 2 * PER; k++) begin
      step_edge();
      chk(busy == 0 && done == 0, "R1 stays idle after reset", busy, 0);
    end
    run_trace("after reset", 1, 0, 1'b0);
  endtask

  initial begin : watchdog
    #1_000_000;
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset_state();
    t_single();
    t_held_level();
    t_mid_pulses();
    t_back_to_back();
    t_reset_mid();
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule